// File: doc/BRIEF.md
# Trace Capture Buffer

The block is an on-chip store for execution trace. Each trace record carries a program address and a timestamp. A record can also carry a data access, which is an address and a value, tagged with the program address of the instruction that made the access. Records arrive on a valid/ready stream. They are written into a RAM of `DEPTH` entries while capture is enabled. Capture is enabled either by the trigger unit's enable level or by a manual start. A record with a data access takes two RAM entries: a program word first, then a data word. So such a record needs two write cycles.

Two capture modes are selectable. One-shot capture keeps the earliest entries and halts by itself when the next record no longer fits. Circular capture overwrites the oldest entries until a trigger stop or a manual stop ends it. A second selection sets what happens when the ingress is busy writing the second word of a data record:
- **Stall mode:** the block drops `in_ready` and raises a stall request to the core, so no record is lost.
- **Drop mode:** the block never back-pressures. It discards the record that cannot be taken and sets a gap mark on the next stored entry.

Back-pressure rule on the ingress stream: a record is consumed on every cycle where `in_valid` and `in_ready` are both high. In drop mode `in_ready` is tied high. Once capture has halted, the block reports how many entries it holds. A readback stream then returns the entries oldest-first. The readback stream holds its beat stable until `rd_ready` is high.

Top module: `trace_capture_buffer`

## Requirements
- R1: With `cfg_circular`=0, capture halts at the edge that stores the entry filling all `DEPTH` slots. It also halts, leaving that record unstored, when a data record is offered with fewer than two free slots. Either way `st_full` rises and the earliest entries are kept.
- R2: With `cfg_circular`=1, writing past the last slot wraps to slot 0 and overwrites the oldest entries. `st_wrapped` then reads 1 and the entry count stays at `DEPTH`.
- R3: After `rd_start`, readback returns every held entry once, oldest-first. It starts at the write position if wrapped, otherwise at slot 0. A beat is held until `rd_ready`, and `rd_last` marks the final beat.
- R4: With `cfg_stall`=1, in the cycle after a data record is taken, `in_ready` is 0 and `stall_req` equals `in_valid`. The offered record is taken one cycle later, and no record is lost.
- R5: With `cfg_stall`=0, `in_ready` is always 1 and `stall_req` is always 0. A record offered while the data word is still pending is discarded, and the next stored entry has its gap bit set to 1.
- R6: A program entry has `rd_is_data`=0 and payload {pc, ts}, with pc in the upper 32 bits. A data record stores its program entry and then a data entry with `rd_is_data`=1 and payload {daddr, dval}.
- R7: Without a manual start in force, records offered while `trig_en` is 0 are consumed and discarded. They set no gap mark.
- R8: A `man_start` pulse empties the buffer and captures every offered record regardless of `trig_en`. A `man_stop` pulse halts capture even while `trig_en` is 1.
- R9: A `trig_stop` pulse halts capture. No entry is written after the halt, except the pending second word of a data record.
- R10: `rd_start` is ignored while capture runs. `fill_count` reads 0 while capture runs and the number of held entries once halted.
- R11: After reset the block is capturing under trigger control and is empty. `in_ready`=1, and `stall_req`, `rd_valid`, `st_full` and `st_wrapped` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_circular | input | 1 | 1 = circular capture, 0 = one-shot |
| cfg_stall | input | 1 | 1 = stall the core, 0 = drop with gap mark |
| trig_en | input | 1 | Capture enable level from the trigger unit |
| trig_stop | input | 1 | Stop pulse from the trigger unit |
| man_start | input | 1 | Manual start pulse: clear and force capture |
| man_stop | input | 1 | Manual stop pulse |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Record accepted this cycle when high with in_valid |
| in_has_data | input | 1 | Record carries a data access |
| in_pc | input | 32 | Program address |
| in_ts | input | 32 | Timestamp |
| in_daddr | input | 32 | Data access address |
| in_dval | input | 32 | Data access value |
| stall_req | output | 1 | Stall request to the core |
| rd_start | input | 1 | Begin readback (halted only) |
| rd_valid | output | 1 | Readback beat valid |
| rd_ready | input | 1 | Readback beat taken |
| rd_is_data | output | 1 | Beat is a data entry |
| rd_gap | output | 1 | Records were dropped just before this entry |
| rd_payload | output | 64 | Entry payload |
| rd_last | output | 1 | Final beat of the readback |
| st_capturing | output | 1 | Capture running |
| st_full | output | 1 | One-shot capture halted for lack of room |
| st_wrapped | output | 1 | Circular write position has wrapped |
| fill_count | output | clog2(DEPTH+1) | Held entries (0 while capturing) |

## Verification
The bench builds the block with `DEPTH`=8. With that depth, filling the one-shot buffer takes a handful of records. Wrapping the circular buffer takes ten entries, which leaves the oldest entry at slot 2, so readback must start mid-array and cross the end. The small depth also puts the one-slot-short case for a two-entry data record, and the readback of a full buffer with alternating `rd_ready`, within a few dozen cycles.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int PC_W = 32;
  localparam int TS_W = 32;
  localparam int DA_W = 32;
  localparam int DV_W = 32;
  localparam int PAY_W = (PC_W + TS_W > DA_W + DV_W) ? PC_W + TS_W : DA_W + DV_W;

  typedef struct packed {
    logic             is_data;
    logic             gap;
    logic [PAY_W-1:0] payload;
  } trc_entry_t;
endpackage

// File: rtl/trc_ingress.sv
module trc_ingress
  import trc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            gate,
  input  logic            stall_mode,
  input  logic            room_one,
  input  logic            room_two,
  input  logic            in_valid,
  input  logic            in_has_data,
  input  logic [PC_W-1:0] in_pc,
  input  logic [TS_W-1:0] in_ts,
  input  logic [DA_W-1:0] in_daddr,
  input  logic [DV_W-1:0] in_dval,
  output logic            in_ready,
  output logic            stall_req,
  output logic            wr_en,
  output logic            no_room,
  output logic            busy,
  output trc_entry_t      wr_entry
);
  logic       pending, gap_pend;
  trc_entry_t pend_q, head, tail;
  logic       offer, fits, accept, drop;

  always_comb begin
    head = '0;
    head.gap = gap_pend;
    head.payload[PC_W+TS_W-1:0] = {in_pc, in_ts};
    tail = '0;
    tail.is_data = 1'b1;
    tail.payload[DA_W+DV_W-1:0] = {in_daddr, in_dval};
  end

  assign offer     = in_valid & gate & ~pending;
  assign fits      = in_has_data ? room_two : room_one;
  assign accept    = offer & fits;
  assign no_room   = offer & ~fits;
  assign drop      = in_valid & gate & pending & ~stall_mode;
  assign in_ready  = ~(stall_mode & gate & pending);
  assign stall_req = stall_mode & gate & pending & in_valid;
  assign wr_en     = pending | accept;
  assign wr_entry  = pending ? pend_q : head;
  assign busy      = pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      gap_pend <= 1'b0;
      pend_q   <= '0;
    end else if (clear) begin
      pending  <= 1'b0;
      gap_pend <= 1'b0;
    end else begin
      pending <= accept & in_has_data;
      if (accept & in_has_data) pend_q <= tail;
      if (drop) gap_pend <= 1'b1;
      else if (accept) gap_pend <= 1'b0;
    end
  end

  p_drop_never_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_mode |-> (in_ready && !stall_req));
  p_stall_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> !stall_req);
  p_data_after_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_entry.is_data) |-> $past(wr_en && !wr_entry.is_data));
endmodule

// File: rtl/trc_store.sv
module trc_store
  import trc_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  trc_entry_t    wdata,
  input  logic [AW-1:0] raddr,
  output trc_entry_t    rdata
);
  trc_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trc_reader.sv
module trc_reader #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          go,
  input  logic [AW-1:0] start_ptr,
  input  logic [CW-1:0] count,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [AW-1:0] rd_addr
);
  logic          reading;
  logic [AW-1:0] ptr;
  logic [CW-1:0] left;

  assign rd_valid = reading;
  assign rd_last  = reading & (left == CW'(1));
  assign rd_addr  = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      reading <= 1'b0;
      ptr     <= '0;
      left    <= '0;
    end else if (go) begin
      reading <= (count != '0);
      ptr     <= start_ptr;
      left    <= count;
    end else if (reading && rd_ready) begin
      ptr     <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
      left    <= left - CW'(1);
      if (left == CW'(1)) reading <= 1'b0;
    end
  end

  p_hold_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !clear) |=> (rd_valid && $stable(rd_addr)));
endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
  import trc_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_circular,
  input  logic             cfg_stall,
  input  logic             trig_en,
  input  logic             trig_stop,
  input  logic             man_start,
  input  logic             man_stop,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_has_data,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [TS_W-1:0]  in_ts,
  input  logic [DA_W-1:0]  in_daddr,
  input  logic [DV_W-1:0]  in_dval,
  output logic             stall_req,
  input  logic             rd_start,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             rd_is_data,
  output logic             rd_gap,
  output logic [PAY_W-1:0] rd_payload,
  output logic             rd_last,
  output logic             st_capturing,
  output logic             st_full,
  output logic             st_wrapped,
  output logic [CW-1:0]    fill_count
);
  logic          stopped, forced, full, wrapped;
  logic [AW-1:0] wr_ptr, rd_addr;
  logic [CW-1:0] cnt;
  logic          gate, room_one, room_two, wr_en, no_room, busy, rd_go, last_slot;
  trc_entry_t    wr_entry, rd_entry;

  assign gate      = ~stopped & (forced | trig_en);
  assign room_one  = cfg_circular | (int'(cnt) < DEPTH);
  assign room_two  = cfg_circular | (int'(cnt) <= DEPTH - 2);
  assign last_slot = (wr_ptr == AW'(DEPTH - 1));
  assign rd_go     = rd_start & stopped & ~busy & ~rd_valid;

  trc_ingress u_ingress (
    .clk, .rst_n, .clear(man_start), .gate, .stall_mode(cfg_stall),
    .room_one, .room_two, .in_valid, .in_has_data, .in_pc, .in_ts,
    .in_daddr, .in_dval, .in_ready, .stall_req, .wr_en, .no_room, .busy,
    .wr_entry
  );

  trc_store #(.DEPTH(DEPTH)) u_store (
    .clk, .we(wr_en), .waddr(wr_ptr), .wdata(wr_entry), .raddr(rd_addr),
    .rdata(rd_entry)
  );

  trc_reader #(.DEPTH(DEPTH)) u_reader (
    .clk, .rst_n, .clear(man_start), .go(rd_go),
    .start_ptr(wrapped ? wr_ptr : '0), .count(cnt), .rd_ready,
    .rd_valid, .rd_last, .rd_addr
  );

  always_ff @(posedge clk) begin
    if (!rst_n || man_start) begin
      stopped <= 1'b0;
      forced  <= man_start;
      full    <= 1'b0;
      wrapped <= 1'b0;
      wr_ptr  <= '0;
      cnt     <= '0;
    end else begin
      if (wr_en) begin
        wr_ptr <= last_slot ? '0 : wr_ptr + AW'(1);
        if (last_slot && cfg_circular) wrapped <= 1'b1;
        if (int'(cnt) != DEPTH) cnt <= cnt + CW'(1);
      end
      if (man_stop || trig_stop) begin
        stopped <= 1'b1;
        forced  <= 1'b0;
      end
      if (!cfg_circular && !stopped &&
          (no_room || (wr_en && int'(cnt) == DEPTH - 1))) begin
        stopped <= 1'b1;
        forced  <= 1'b0;
        full    <= 1'b1;
      end
    end
  end

  assign rd_is_data   = rd_entry.is_data;
  assign rd_gap       = rd_entry.gap;
  assign rd_payload   = rd_entry.payload;
  assign st_capturing = ~stopped;
  assign st_full      = full;
  assign st_wrapped   = wrapped;
  assign fill_count   = stopped ? cnt : '0;

  p_full_halts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> !st_capturing);
  p_wrap_keeps_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_wrapped |-> (int'(cnt) == DEPTH));
  p_read_only_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !st_capturing);
  p_no_write_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !busy) |-> !wr_en);
endmodule

// File: tb/test_trace_capture_buffer.sv
module test_trace_capture_buffer;
  import trc_pkg::*;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = PAY_W + 2;

  logic clk = 1'b0;
  logic rst_n, cfg_circular, cfg_stall, trig_en, trig_stop, man_start, man_stop;
  logic in_valid, in_ready, in_has_data, stall_req;
  logic [PC_W-1:0] in_pc;
  logic [TS_W-1:0] in_ts;
  logic [DA_W-1:0] in_daddr;
  logic [DV_W-1:0] in_dval;
  logic rd_start, rd_valid, rd_is_data, rd_gap, rd_last;
  logic rd_ready = 1'b1;
  logic [PAY_W-1:0] rd_payload;
  logic st_capturing, st_full, st_wrapped;
  logic [CW-1:0] fill_count;
  logic bp_en = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  trc_entry_t exp_q[$];

  always #10 clk = ~clk;

  trace_capture_buffer #(.DEPTH(DEPTH)) i_trace_capture_buffer (
    .clk, .rst_n, .cfg_circular, .cfg_stall, .trig_en, .trig_stop, .man_start,
    .man_stop, .in_valid, .in_ready, .in_has_data, .in_pc, .in_ts, .in_daddr,
    .in_dval, .stall_req, .rd_start, .rd_valid, .rd_ready, .rd_is_data, .rd_gap,
    .rd_payload, .rd_last, .st_capturing, .st_full, .st_wrapped, .fill_count
  );

  task automatic chk(input string req, input string what,
                     input logic [EW-1:0] act, input logic [EW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  function automatic trc_entry_t prog_e(input logic g, input logic [PC_W-1:0] pc,
                                        input logic [TS_W-1:0] ts);
    prog_e = '0;
    prog_e.gap = g;
    prog_e.payload[PC_W+TS_W-1:0] = {pc, ts};
  endfunction

  function automatic trc_entry_t data_e(input logic [DA_W-1:0] da,
                                        input logic [DV_W-1:0] dv);
    data_e = '0;
    data_e.is_data = 1'b1;
    data_e.payload[DA_W+DV_W-1:0] = {da, dv};
  endfunction

  // driver: offers one record and returns once it will be taken at the next edge
  task automatic push(input logic [31:0] pc, input logic [31:0] ts, input logic hd,
                      input logic [31:0] da, input logic [31:0] dv);
    @(negedge clk);
    in_valid = 1'b1; in_has_data = hd; in_pc = pc; in_ts = ts;
    in_daddr = da; in_dval = dv;
    #1;
    if (!cfg_stall) begin
      chk("R5", "in_ready in drop mode", in_ready, 1'b1);
      chk("R5", "stall_req in drop mode", stall_req, 1'b0);
    end
    while (!in_ready) begin
      chk("R4", "stall_req while held", stall_req, 1'b1);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic strobe(input int w);
    @(negedge clk);
    in_valid = 1'b0;
    case (w)
      0: man_start = 1'b1;
      1: man_stop = 1'b1;
      2: trig_stop = 1'b1;
      default: rd_start = 1'b1;
    endcase
    @(negedge clk);
    man_start = 1'b0; man_stop = 1'b0; trig_stop = 1'b0; rd_start = 1'b0;
    #1;
  endtask

  task automatic readout(input bit bp);
    int n;
    bp_en = bp;
    strobe(3);
    n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    #1;
    chk("R3", "entries left unread", exp_q.size(), 0);
    chk("R3", "rd_valid after last beat", rd_valid, 1'b0);
    exp_q.delete();
    bp_en = 1'b0;
  endtask

  always @(posedge clk) rd_ready <= bp_en ? ~rd_ready : 1'b1;

  // monitor: pops the scoreboard on every readback beat
  always @(negedge clk) begin
    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        chk("R3", "unexpected beat", {rd_is_data, rd_gap, rd_payload}, '0);
      end else begin
        trc_entry_t e;
        e = exp_q.pop_front();
        chk("R3 R6", "entry", {rd_is_data, rd_gap, rd_payload}, e);
        chk("R3", "rd_last", rd_last, exp_q.size() == 0);
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R3 act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_circular = 1'b1; cfg_stall = 1'b1; trig_en = 1'b0;
    trig_stop = 1'b0; man_start = 1'b0; man_stop = 1'b0; rd_start = 1'b0;
    in_valid = 1'b0; in_has_data = 1'b0; in_pc = '0; in_ts = '0;
    in_daddr = '0; in_dval = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11 reset state
    chk("R11", "capturing", st_capturing, 1'b1);
    chk("R11", "in_ready", in_ready, 1'b1);
    chk("R11", "stall_req", stall_req, 1'b0);
    chk("R11", "rd_valid", rd_valid, 1'b0);
    chk("R11", "full", st_full, 1'b0);
    chk("R11", "wrapped", st_wrapped, 1'b0);
    chk("R11", "fill_count", fill_count, 0);

    // R7 trigger gating, R9 trigger stop
    push(32'h1000, 32'h1, 1'b0, 0, 0);     // ignored: trig_en low
    idle(0);
    trig_en = 1'b1;
    push(32'h1004, 32'h2, 1'b0, 0, 0); exp_q.push_back(prog_e(1'b0, 32'h1004, 32'h2));
    push(32'h1008, 32'h3, 1'b0, 0, 0); exp_q.push_back(prog_e(1'b0, 32'h1008, 32'h3));
    idle(0);
    trig_en = 1'b0;
    push(32'h100C, 32'h4, 1'b0, 0, 0);     // ignored again
    idle(1);
    strobe(2);
    chk("R9", "halted by trig_stop", st_capturing, 1'b0);
    chk("R7", "only gated records held", fill_count, 2);
    readout(1'b0);

    // R1 one-shot with stall, R4, R6, R10
    cfg_circular = 1'b0; cfg_stall = 1'b1;
    strobe(0);
    chk("R10", "fill_count while capturing", fill_count, 0);
    chk("R1", "full cleared by start", st_full, 1'b0);
    push(32'h2000, 32'h10, 1'b1, 32'hA0, 32'hD0);
    exp_q.push_back(prog_e(1'b0, 32'h2000, 32'h10));
    exp_q.push_back(data_e(32'hA0, 32'hD0));       // R6 two entries
    push(32'h2004, 32'h11, 1'b0, 0, 0);            // R4 held one cycle
    exp_q.push_back(prog_e(1'b0, 32'h2004, 32'h11));
    idle(1);
    strobe(3);
    chk("R10", "rd_start ignored while capturing", rd_valid, 1'b0);
    for (int i = 0; i < 5; i++) begin
      push(32'h2100 + i, 32'h20 + i, 1'b0, 0, 0);
      exp_q.push_back(prog_e(1'b0, 32'h2100 + i, 32'h20 + i));
    end
    idle(0);
    chk("R1", "full flag", st_full, 1'b1);
    chk("R1", "halted when full", st_capturing, 1'b0);
    chk("R1", "count at depth", fill_count, DEPTH);
    push(32'h2200, 32'h30, 1'b0, 0, 0);            // after halt: ignored
    idle(1);
    chk("R1", "count unchanged after halt", fill_count, DEPTH);
    readout(1'b1);

    // R1 one-shot: data record without two free slots
    cfg_stall = 1'b0;
    strobe(0);
    for (int i = 0; i < 7; i++) begin
      push(32'h3000 + i, 32'h40 + i, 1'b0, 0, 0);
      exp_q.push_back(prog_e(1'b0, 32'h3000 + i, 32'h40 + i));
    end
    push(32'h3100, 32'h50, 1'b1, 32'hB0, 32'hE0);
    idle(1);
    chk("R1", "full on no room", st_full, 1'b1);
    chk("R1", "no-room record not stored", fill_count, 7);
    readout(1'b0);

    // R2 circular wrap, R5 drop with gap, R8 manual stop
    cfg_circular = 1'b1; cfg_stall = 1'b0;
    strobe(0);
    push(32'h4000, 32'h60, 1'b1, 32'hC0, 32'hF0);  // two entries, later overwritten
    push(32'h4004, 32'h61, 1'b0, 0, 0);            // dropped: data word pending
    push(32'h4008, 32'h62, 1'b0, 0, 0);
    exp_q.push_back(prog_e(1'b1, 32'h4008, 32'h62)); // R5 gap mark
    for (int i = 0; i < 7; i++) begin
      push(32'h4100 + i, 32'h70 + i, 1'b0, 0, 0);
      exp_q.push_back(prog_e(1'b0, 32'h4100 + i, 32'h70 + i));
    end
    idle(0);
    trig_en = 1'b1;
    strobe(1);
    chk("R8", "man_stop halts with trig_en high", st_capturing, 1'b0);
    chk("R2", "wrapped", st_wrapped, 1'b1);
    chk("R2", "count stays depth", fill_count, DEPTH);
    readout(1'b1);

    // R8 manual start overrides trig_en low, stop overrides it high
    trig_en = 1'b0;
    strobe(0);
    chk("R8", "start empties buffer", st_wrapped, 1'b0);
    push(32'h5000, 32'h80, 1'b0, 0, 0);
    exp_q.push_back(prog_e(1'b0, 32'h5000, 32'h80));
    idle(0);
    trig_en = 1'b1;
    strobe(1);
    push(32'h5004, 32'h81, 1'b0, 0, 0);            // ignored after stop
    idle(1);
    chk("R8", "forced capture then stop", fill_count, 1);
    readout(1'b0);

    finish_run();
  end
endmodule